// File: doc/BRIEF.md
# Serial Command Register Port

This block receives 32-bit command words over a three-wire serial link (chip select, serial clock, serial data) and uses them to update the configuration held for a clock synthesizer. The serial lines are asynchronous to the core clock. They are brought into the core domain through two-flop synchronizers and then edge-detected, so every register and every output of the block belongs to the core clock domain. For this to work, each serial clock phase must last several core clock cycles.

A frame is sent least significant bit first. The frame carries a 2-bit target code followed by 30 data bits, and it takes effect when chip select returns high. Three targets exist:
- a frequency word, made up of the reference divider, the feedback divider and the output divide select;
- a mode word, holding the trigger, pulse and halt controls;
- a restart command for the synchronized output clock.

The restart command uses a two-step handshake. The first write holds the output clock. An immediately following clearing write releases the clock and emits a single-cycle sync strobe.

Top module: `cmd_port`

## Requirements
- R1: After rst_ni is released, the outputs hold their defaults: ref_div_o=200, fb_div_o=4000, out_div_o=1, every mode output 0, clk_hold_o=0 and sync_o=0.
- R2: Frame bit k is sampled on the k-th rising edge of sclk_i while cs_ni is low, with bit 0 sent first. Frame bits [1:0] form the target code and frame bits [31:2] form data bits D0..D29. Target code 0 loads ref_div_o=D11..D0, fb_div_o=D26..D12 and out_div_o=D29..D27.
- R3: Target code 2 loads trig_edge_o=D1..D0, spike_rm_o=D2, pulse_pol_o=D3, pulse_w_o=D5..D4, out_sel_o=D6, halt_all_o=D7 and vco_halt_o=D8. Bits D9..D29 have no effect on any output.
- R4: A frame commits only when cs_ni rises after exactly 32 sclk_i rising edges. Frames of 31 or 33 bits change nothing.
- R5: A frame with target code 1 changes no output.
- R6: A target code 3 frame with D0=1 sets clk_hold_o to 1 and does not pulse sync_o.
- R7: If the committed frame that directly follows an R6 frame is target code 3 with D0=0, sync_o pulses once and clk_hold_o returns to 0.
- R8: A target code 3 frame with D0=0 that does not directly follow an R6 frame changes nothing. Any other committed frame in between cancels the pending restart.
- R9: While cs_ni is high, activity on sclk_i and sdi_i changes no output.
- R10: Every sync_o pulse lasts exactly one clk_i cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock, asynchronous |
| cs_ni | input | 1 | Active-low chip select, asynchronous |
| sdi_i | input | 1 | Serial data, asynchronous |
| ref_div_o | output | 12 | Reference divide ratio |
| fb_div_o | output | 15 | Feedback divide ratio |
| out_div_o | output | 3 | Output divide select |
| trig_edge_o | output | 2 | Trigger edge/level select |
| spike_rm_o | output | 1 | Spike removal enable |
| pulse_pol_o | output | 1 | One-shot pulse polarity |
| pulse_w_o | output | 2 | One-shot pulse width select |
| out_sel_o | output | 1 | Output mux select |
| halt_all_o | output | 1 | Global halt |
| vco_halt_o | output | 1 | Oscillator and charge pump halt |
| clk_hold_o | output | 1 | Synchronized clock held by restart command |
| sync_o | output | 1 | Single-cycle sync strobe |

## Verification
Four properties hold on every cycle and are checked by assertions:
- the configuration words stay stable in every cycle without a commit;
- a commit only follows a chip-select rise;
- the sync strobe never lasts more than one cycle;
- each strobe coincides with the release of the clock hold.

Other properties can only be shown by the bench's scenarios:
- the bit order and the field placement within a frame;
- that frames of the wrong length and the unused target code are discarded;
- that test bits are ignored;
- the pairing rule of the restart command, including a cancelled pairing.

// File: rtl/cmd_port_pkg.sv
package cmd_port_pkg;
  parameter int unsigned FRAME_W = 32;
  parameter int unsigned ADDR_W  = 2;
  parameter int unsigned REF_W   = 12;
  parameter int unsigned FB_W    = 15;
  parameter int unsigned ODIV_W  = 3;
  localparam int unsigned DATA_W = FRAME_W - ADDR_W;
  localparam int unsigned CNT_W  = $clog2(FRAME_W + 2);

  typedef enum logic [ADDR_W-1:0] {
    TGT_FREQ  = 2'd0,
    TGT_NONE  = 2'd1,
    TGT_MODE  = 2'd2,
    TGT_DUMMY = 2'd3
  } tgt_e;

  typedef struct packed {
    logic [ODIV_W-1:0] odiv;
    logic [FB_W-1:0]   fb;
    logic [REF_W-1:0]  rdiv;
  } freq_t;

  typedef struct packed {
    logic       vco_halt;
    logic       halt_all;
    logic       out_sel;
    logic [1:0] pulse_w;
    logic       pulse_pol;
    logic       spike_rm;
    logic [1:0] trig_edge;
  } mode_t;

  localparam int unsigned MODE_W = $bits(mode_t);
endpackage

// File: rtl/cp_sync.sv
module cp_sync #(
  parameter int unsigned W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/cp_shifter.sv
module cp_shifter
  import cmd_port_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sclk_s_i,
  input  logic               cs_s_i,
  input  logic               sdi_s_i,
  output logic               frame_vld_o,
  output logic [FRAME_W-1:0] frame_o
);
  localparam logic [CNT_W-1:0] CNT_CAP  = CNT_W'(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

  logic               sclk_d, cs_d;
  logic               sclk_rise, cs_rise;
  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-1:0] sr_q;

  assign sclk_rise = sclk_s_i & ~sclk_d;
  assign cs_rise   = cs_s_i & ~cs_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d      <= 1'b0;
      cs_d        <= 1'b1;
      cnt_q       <= '0;
      sr_q        <= '0;
      frame_vld_o <= 1'b0;
    end else begin
      sclk_d      <= sclk_s_i;
      cs_d        <= cs_s_i;
      frame_vld_o <= cs_rise && (cnt_q == CNT_FULL);
      if (cs_s_i) begin
        cnt_q <= '0;
      end else if (sclk_rise) begin
        sr_q  <= {sdi_s_i, sr_q[FRAME_W-1:1]};  // LSB first
        if (cnt_q != CNT_CAP) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign frame_o = sr_q;

  p_commit_on_cs_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_vld_o |-> ($past(cs_s_i) && !$past(cs_d)));

  p_no_shift_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cs_s_i) |-> $stable(sr_q));
endmodule

// File: rtl/cp_regs.sv
module cp_regs
  import cmd_port_pkg::*;
#(
  parameter logic [REF_W-1:0]  REF_DEF  = 12'd200,
  parameter logic [FB_W-1:0]   FB_DEF   = 15'd4000,
  parameter logic [ODIV_W-1:0] ODIV_DEF = 3'd1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               frame_vld_i,
  input  logic [FRAME_W-1:0] frame_i,
  output freq_t              freq_o,
  output mode_t              mode_o,
  output logic               hold_o,
  output logic               sync_o
);
  tgt_e              tgt;
  logic [DATA_W-1:0] data;
  logic              armed_q;

  assign tgt  = tgt_e'(frame_i[ADDR_W-1:0]);
  assign data = frame_i[FRAME_W-1:ADDR_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      freq_o  <= '{odiv: ODIV_DEF, fb: FB_DEF, rdiv: REF_DEF};
      mode_o  <= '0;
      hold_o  <= 1'b0;
      armed_q <= 1'b0;
      sync_o  <= 1'b0;
    end else begin
      sync_o <= 1'b0;
      if (frame_vld_i) begin
        armed_q <= 1'b0;
        unique case (tgt)
          TGT_FREQ:  freq_o <= freq_t'(data[REF_W+FB_W+ODIV_W-1:0]);
          TGT_MODE:  mode_o <= mode_t'(data[MODE_W-1:0]);  // test bits dropped
          TGT_DUMMY: begin
            if (data[0]) begin
              armed_q <= 1'b1;
              hold_o  <= 1'b1;
            end else if (armed_q) begin
              hold_o <= 1'b0;
              sync_o <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  p_stable_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(frame_vld_i) |-> ($stable(freq_o) && $stable(mode_o) && $stable(hold_o)));

  p_sync_one_cycle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |=> !sync_o);

  p_sync_releases_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |-> $fell(hold_o));

  p_sync_needs_commit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |-> $past(frame_vld_i));
endmodule

// File: rtl/cmd_port.sv
module cmd_port
  import cmd_port_pkg::*;
#(
  parameter logic [REF_W-1:0]  REF_DEF  = 12'd200,
  parameter logic [FB_W-1:0]   FB_DEF   = 15'd4000,
  parameter logic [ODIV_W-1:0] ODIV_DEF = 3'd1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic              sdi_i,
  output logic [REF_W-1:0]  ref_div_o,
  output logic [FB_W-1:0]   fb_div_o,
  output logic [ODIV_W-1:0] out_div_o,
  output logic [1:0]        trig_edge_o,
  output logic              spike_rm_o,
  output logic              pulse_pol_o,
  output logic [1:0]        pulse_w_o,
  output logic              out_sel_o,
  output logic              halt_all_o,
  output logic              vco_halt_o,
  output logic              clk_hold_o,
  output logic              sync_o
);
  logic [2:0]         ser_s;
  logic               frame_vld;
  logic [FRAME_W-1:0] frame;
  freq_t              freq;
  mode_t              mode;

  // order: {sclk, cs, sdi}; chip select idles high
  cp_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sclk_i, cs_ni, sdi_i}),
    .q_o   (ser_s)
  );

  cp_shifter u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sclk_s_i   (ser_s[2]),
    .cs_s_i     (ser_s[1]),
    .sdi_s_i    (ser_s[0]),
    .frame_vld_o(frame_vld),
    .frame_o    (frame)
  );

  cp_regs #(.REF_DEF(REF_DEF), .FB_DEF(FB_DEF), .ODIV_DEF(ODIV_DEF)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .frame_vld_i(frame_vld),
    .frame_i    (frame),
    .freq_o     (freq),
    .mode_o     (mode),
    .hold_o     (clk_hold_o),
    .sync_o     (sync_o)
  );

  assign ref_div_o   = freq.rdiv;
  assign fb_div_o    = freq.fb;
  assign out_div_o   = freq.odiv;
  assign trig_edge_o = mode.trig_edge;
  assign spike_rm_o  = mode.spike_rm;
  assign pulse_pol_o = mode.pulse_pol;
  assign pulse_w_o   = mode.pulse_w;
  assign out_sel_o   = mode.out_sel;
  assign halt_all_o  = mode.halt_all;
  assign vco_halt_o  = mode.vco_halt;
endmodule

// File: tb/sim_cmd_port.sv
module sim_cmd_port;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0;
  logic [11:0] ref_div; logic [14:0] fb_div; logic [2:0] out_div;
  logic [1:0] trig_edge, pulse_w;
  logic spike_rm, pulse_pol, out_sel, halt_all, vco_halt, clk_hold, sync;

  int total = 0, bad = 0;
  int rises = 0, hi_cycles = 0;
  logic sync_prev = 1'b0;

  // model
  logic [29:0] m_freq;
  logic [8:0]  m_mode;
  logic m_hold, m_armed;
  int m_syncs;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n), .sdi_i(sdi),
    .ref_div_o(ref_div), .fb_div_o(fb_div), .out_div_o(out_div),
    .trig_edge_o(trig_edge), .spike_rm_o(spike_rm), .pulse_pol_o(pulse_pol),
    .pulse_w_o(pulse_w), .out_sel_o(out_sel), .halt_all_o(halt_all),
    .vco_halt_o(vco_halt), .clk_hold_o(clk_hold), .sync_o(sync)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (sync) hi_cycles++;
      if (sync && !sync_prev) rises++;
    end
    sync_prev = sync;
  end

  function automatic void model(input logic [31:0] w);
    logic [1:0] a = w[1:0];
    logic [29:0] d = w[31:2];
    logic was_armed = m_armed;
    m_armed = 1'b0;
    case (a)
      2'd0: m_freq = d;
      2'd2: m_mode = d[8:0];
      2'd3: begin
        if (d[0]) begin m_armed = 1'b1; m_hold = 1'b1; end
        else if (was_armed) begin m_hold = 1'b0; m_syncs++; end
      end
      default: ;
    endcase
  endfunction

  task automatic check(input string tag);
    logic [29:0] af = {out_div, fb_div, ref_div};
    logic [8:0]  am = {vco_halt, halt_all, out_sel, pulse_w, pulse_pol, spike_rm, trig_edge};
    total++;
    if (af !== m_freq) begin bad++; $display("FAIL %s freq act=%h exp=%h", tag, af, m_freq); end
    total++;
    if (am !== m_mode) begin bad++; $display("FAIL %s mode act=%h exp=%h", tag, am, m_mode); end
    total++;
    if (clk_hold !== m_hold) begin bad++; $display("FAIL %s hold act=%b exp=%b", tag, clk_hold, m_hold); end
    total++;
    if (rises != m_syncs) begin bad++; $display("FAIL %s syncs act=%0d exp=%0d", tag, rises, m_syncs); end
    total++;
    if (hi_cycles != m_syncs) begin bad++; $display("FAIL R10 %s sync cycles act=%0d exp=%0d", tag, hi_cycles, m_syncs); end
  endtask

  task automatic send(input logic [31:0] w, input int n);
    @(negedge clk) cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      sdi = (i < 32) ? w[i] : 1'($urandom);
      repeat (HALF) @(negedge clk);
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
    if (n == 32) model(w);
  endtask

  function automatic logic [31:0] fr(input logic [1:0] a, input logic [29:0] d);
    return {d, a};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    m_freq = {3'd1, 15'd4000, 12'd200}; m_mode = '0;
    m_hold = 0; m_armed = 0; m_syncs = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 reset");

    send(fr(2'd0, {3'd5, 15'h1234, 12'habc}), 32); check("R2 freq fields");
    send(fr(2'd2, {21'h1fffff, 9'h0a5}), 32);      check("R3 mode with test bits");
    send(fr(2'd0, 30'h3fff_ffff), 31);             check("R4 short frame");
    send(fr(2'd0, 30'h0), 33);                     check("R4 long frame");
    send(fr(2'd1, 30'h2aaa_aaaa), 32);             check("R5 unused target");
    send(fr(2'd3, 30'h1), 32);                     check("R6 hold set");
    send(fr(2'd3, 30'h0), 32);                     check("R7 restart");
    send(fr(2'd3, 30'h0), 32);                     check("R8 unpaired clear");
    send(fr(2'd3, 30'h1), 32);
    send(fr(2'd2, 30'h0), 32);
    send(fr(2'd3, 30'h0), 32);                     check("R8 cancelled pairing");
    send(fr(2'd3, 30'h1), 32);
    send(fr(2'd3, 30'h0), 32);                     check("R7 second restart");

    // R9: serial activity with chip select high
    for (int i = 0; i < 40; i++) begin
      sdi = 1'($urandom);
      repeat (HALF) @(negedge clk); sclk = 1'b1;
      repeat (HALF) @(negedge clk); sclk = 1'b0;
    end
    repeat (8) @(negedge clk);
    check("R9 idle activity");

    for (int k = 0; k < 60; k++) begin
      logic [1:0] a = 2'($urandom);
      logic [29:0] d = 30'($urandom);
      int len = ($urandom % 6 == 0) ? ((($urandom & 1) != 0) ? 31 : 33) : 32;
      if (a == 2'd3) d = {29'($urandom), 1'($urandom)};
      send(fr(a, d), len);
      check(len == 32 ? "R2 R3 R7 random" : "R4 random length");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule